// File: doc/BRIEF.md
# Serial Register-Access Slave with Burst Addressing

This block lets a host processor read and write a byte-wide register file through a four-wire serial port: an active-low select, a serial clock, a data input and a data output. Each access opens with a 16-bit command word that carries a direction flag, a byte count and a 10-bit start address. One to eight data bytes follow. An internal pointer moves from byte to byte, downward when the port is framed most-significant-bit first and upward when it is framed least-significant-bit first. When a burst ends while the select is still low, the next 16 clocks are read as a fresh command, so accesses can be chained with no gap.

The serial pins are oversampled by the block's own system clock through a short synchronizer chain. Input data is captured on each rising serial clock edge and output data changes after each falling edge. On the other side, a plain parallel port drives an address, a one-cycle write strobe and write data, and it takes read data back combinationally from the register file. Addresses at or above `NUM_REGS` are undefined. The block accepts them without complaint, drops writes to them and returns zero on reads from them.

Top module: `serial_regport`

## Requirements
- R1: The command word is 16 bits. Bit 15 is the direction (1 = write, 0 = read), bits 14:12 are the count field, bits 11:10 are ignored whatever their value, and bits 9:0 are the start address. With `lsb_first` low, bit 15 is shifted in first. `sdi` is captured on rising edges of `sclk`, and each `sclk` level lasts at least 4 `clk` cycles.
- R2: A count field of n transfers n+1 bytes. A field of 000 transfers exactly one byte, and 111 transfers eight.
- R3: With `lsb_first` low, each data byte travels bit 7 first and the byte address drops by one after every byte.
- R4: With `lsb_first` high, the whole command word is shifted bit 0 first (address, then the unused pair, then the count field, then the direction last), each data byte travels bit 0 first, and the byte address rises by one after every byte.
- R5: Generated addresses wrap modulo 1024 in both directions.
- R6: Addresses at or above `NUM_REGS` (640 by default) are undefined. A write to one gives no `reg_we` pulse, a read from one returns 0x00 on `sdo`, and the burst goes on normally.
- R7: After the eighth rising edge of a write byte, `reg_we` is high for exactly one `clk` cycle. During that cycle `reg_addr` holds that byte's address and `reg_wdata` holds the byte.
- R8: During a read, `sdo` moves to its next bit after each falling edge of `sclk`, so every bit is stable before the rising edge that follows. The byte sent is `reg_rdata` at that byte's address.
- R9: When the last byte of a burst completes with `cs_n` still low, the next 16 rising edges form a new command word.
- R10: Taking `cs_n` high ends the access at once. A partly received byte is never written, `sdo` returns to 0, and the next selection starts with a command word.
- R11: After reset `reg_we` and `sdo` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsb_first | input | 1 | Static framing select: 1 = least significant bit first |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host, idles low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host, 0 when idle |
| reg_addr | output | ADDR_W | Register-file byte address |
| reg_we | output | 1 | One-cycle write strobe to the register file |
| reg_wdata | output | 8 | Write data to the register file |
| reg_rdata | input | 8 | Read data from the register file at `reg_addr` |

## Verification
A wrong bit counter or framing selection shows up within the first command word. The decoded address is then wrong, so the first write strobe carries a wrong address, or the first read byte on `sdo` differs from what the register model holds, one serial clock after the bad bit. A pointer that steps the wrong way or does not wrap shows up on the second byte of a burst. A wrong undefined-address decode shows up as a stray strobe or a nonzero read byte on that very byte. A faulty abort shows up as a write strobe after `cs_n` rises, or as a misdecoded next command.

// File: rtl/serial_regport_pkg.sv
package serial_regport_pkg;

   // Fixed framing of the serial command word and data bytes
   localparam int INSTR_W      = 16;
   localparam int BYTE_W       = 8;
   localparam int RW_BIT       = 15;
   localparam int CNT_HI       = 14;
   localparam int CNT_LO       = 12;
   localparam int CNT_FW       = CNT_HI - CNT_LO + 1;
   localparam int ADDR_FIELD_W = 10;

   typedef enum logic {
      PH_INSTR = 1'b0,
      PH_DATA  = 1'b1
   } phase_t;

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         for (int i = STAGES - 1; i > 0; i--) begin
            stg[i] <= stg[i-1];
         end
         stg[0] <= d;
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/srp_addr_gen.sv
module srp_addr_gen #(
   parameter int ADDR_W   = 10,
   parameter int NUM_REGS = 640
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   input  logic              down,
   output logic [ADDR_W-1:0] addr,
   output logic              addr_ok
);

   localparam int SPACE = 2 ** ADDR_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= load_addr;
      end else if (step) begin
         // natural width arithmetic gives the modulo wrap
         addr <= down ? addr - ADDR_W'(1) : addr + ADDR_W'(1);
      end
   end

   generate
      if (NUM_REGS >= SPACE) begin : g_full_map
         assign addr_ok = 1'b1;
      end else begin : g_part_map
         assign addr_ok = (addr < ADDR_W'(NUM_REGS));
      end
   endgenerate

endmodule

// File: rtl/srp_engine.sv
module srp_engine
   import serial_regport_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              sdi_s,
   input  logic              lsb_first,
   input  logic              addr_ok,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              load,
   output logic [ADDR_W-1:0] load_addr,
   output logic              step,
   output logic              we,
   output logic [BYTE_W-1:0] wdata,
   output logic              sdo,
   output phase_t            phase
);

   localparam int BC_W  = $clog2(INSTR_W);
   localparam int BIT_W = $clog2(BYTE_W);

   logic [INSTR_W-1:0] shreg;
   logic [INSTR_W-1:0] nxt;
   logic [BC_W-1:0]    bcnt;
   logic               wr_flag;
   logic [CNT_FW-1:0]  left;
   logic [BYTE_W-1:0]  byte_in;
   logic [BIT_W-1:0]   tx_idx;
   logic               instr_done;
   logic               byte_done;

   // Shift direction alone realises the bit order of both framings
   always_comb begin
      nxt        = lsb_first ? {sdi_s, shreg[INSTR_W-1:1]}
                             : {shreg[INSTR_W-2:0], sdi_s};
      byte_in    = lsb_first ? nxt[INSTR_W-1 -: BYTE_W] : nxt[BYTE_W-1:0];
      instr_done = (phase == PH_INSTR) && (bcnt == BC_W'(INSTR_W - 1));
      byte_done  = (phase == PH_DATA)  && (bcnt == BC_W'(BYTE_W - 1));
      tx_idx     = lsb_first ? bcnt[BIT_W-1:0] : ~bcnt[BIT_W-1:0];
   end

   assign load      = cs_act & sck_rise & instr_done;
   assign load_addr = nxt[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_INSTR;
         shreg   <= '0;
         bcnt    <= '0;
         wr_flag <= 1'b0;
         left    <= '0;
         we      <= 1'b0;
         step    <= 1'b0;
         wdata   <= '0;
         sdo     <= 1'b0;
      end else begin
         we   <= 1'b0;
         step <= 1'b0;
         if (!cs_act) begin
            phase <= PH_INSTR;
            bcnt  <= '0;
            sdo   <= 1'b0;
         end else begin
            if (sck_rise) begin
               shreg <= nxt;
               if (instr_done) begin
                  wr_flag <= nxt[RW_BIT];
                  left    <= nxt[CNT_HI:CNT_LO];
                  phase   <= PH_DATA;
                  bcnt    <= '0;
               end else if (byte_done) begin
                  we    <= wr_flag & addr_ok;
                  wdata <= byte_in;
                  step  <= 1'b1;
                  bcnt  <= '0;
                  if (left == '0) begin
                     phase <= PH_INSTR;
                  end else begin
                     left <= left - 1'b1;
                  end
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            if (sck_fall) begin
               sdo <= (phase == PH_DATA && !wr_flag) ? rd_byte[tx_idx] : 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/serial_regport.sv
module serial_regport
   import serial_regport_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int NUM_REGS    = 640,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lsb_first,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_we,
   output logic [BYTE_W-1:0] reg_wdata,
   input  logic [BYTE_W-1:0] reg_rdata
);

   generate
      if (ADDR_W < 1 || ADDR_W > ADDR_FIELD_W) begin : g_bad_addr_w
         $error("serial_regport: ADDR_W must lie in 1..10");
      end
      if (NUM_REGS < 1 || NUM_REGS > 2 ** ADDR_W) begin : g_bad_num_regs
         $error("serial_regport: NUM_REGS must lie in 1..2**ADDR_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serial_regport: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              cs_s;
   logic              sck_s;
   logic              sdi_s;
   logic              sck_d;
   logic              sck_rise;
   logic              sck_fall;
   logic              cs_act;
   logic              load;
   logic [ADDR_W-1:0] load_addr;
   logic              step;
   logic              addr_ok;
   logic [BYTE_W-1:0] rd_byte;
   phase_t            phase;

   // Select resets high so the port starts deselected
   srp_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdi}),
      .q     ({cs_s, sck_s, sdi_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
      end else begin
         sck_d <= sck_s;
      end
   end

   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;
   assign cs_act   = ~cs_s;

   srp_addr_gen #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (load_addr),
      .step      (step),
      .down      (~lsb_first),
      .addr      (reg_addr),
      .addr_ok   (addr_ok)
   );

   assign rd_byte = addr_ok ? reg_rdata : '0;

   srp_engine #(
      .ADDR_W (ADDR_W)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .sdi_s     (sdi_s),
      .lsb_first (lsb_first),
      .addr_ok   (addr_ok),
      .rd_byte   (rd_byte),
      .load      (load),
      .load_addr (load_addr),
      .step      (step),
      .we        (reg_we),
      .wdata     (reg_wdata),
      .sdo       (sdo),
      .phase     (phase)
   );

endmodule

// File: rtl/serial_regport_chk.sv
module serial_regport_chk
   import serial_regport_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int NUM_REGS = 640
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lsb_first,
   input logic              cs_act,
   input logic              step,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              sdo,
   input phase_t            phase
);

   // R7
   we_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R6
   we_defined_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (int'(reg_addr) < NUM_REGS));

   // R10
   no_write_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> !reg_we);

   // R10
   deselect_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (phase == PH_INSTR) && !sdo);

   // R3
   msb_step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !lsb_first) |=> (reg_addr == $past(reg_addr) - ADDR_W'(1)));

   // R4
   lsb_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && lsb_first) |=> (reg_addr == $past(reg_addr) + ADDR_W'(1)));

endmodule

bind serial_regport serial_regport_chk #(
   .ADDR_W   (ADDR_W),
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lsb_first (lsb_first),
   .cs_act    (cs_act),
   .step      (step),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .sdo       (sdo),
   .phase     (phase)
);

// File: tb/serial_regport_tb.sv
module serial_regport_tb;

   localparam int NREG = 640;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lsb = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic       sdo;
   logic [9:0] reg_addr;
   logic       reg_we;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;

   logic [7:0] regs [1024];
   logic [7:0] wbuf [8];
   int         exp_a [$];
   int         exp_d [$];
   int         checks = 0;
   int         errors = 0;
   int         idle_cnt = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   assign reg_rdata = regs[reg_addr];

   serial_regport u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .lsb_first (lsb),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .sdi       (sdi),
      .sdo       (sdo),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // Register-file model and per-clock comparison of the parallel side
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_we) begin
            if (exp_a.size() == 0) begin
               // R6 R10: a strobe nobody expected
               check(1'b0, "R6/R10", "unexpected reg_we at addr", int'(reg_addr), -1);
            end else begin
               // R7
               check(int'(reg_addr) == exp_a[0], "R7", "write address", int'(reg_addr), exp_a[0]);
               check(int'(reg_wdata) == exp_d[0], "R7", "write data", int'(reg_wdata), exp_d[0]);
               void'(exp_a.pop_front());
               void'(exp_d.pop_front());
            end
            regs[reg_addr] = reg_wdata;
         end
         idle_cnt = cs_n ? idle_cnt + 1 : 0;
         if (idle_cnt > 6) begin
            // R10: deselected output stays low
            check(sdo == 1'b0, "R10", "sdo while deselected", int'(sdo), 0);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input bit b, output bit got);
      sdi = b;
      tick(HALF);
      got = sdo;
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
   endtask

   task automatic sel();
      cs_n = 1'b0;
      tick(HALF);
   endtask

   task automatic desel();
      tick(HALF);
      cs_n = 1'b1;
      sdi = 1'b0;
      tick(4 * HALF);
   endtask

   // R1: bits 11:10 are sent as ones to show they are ignored
   task automatic send_cmd(input bit wr, input int cnt, input int addr);
      logic [15:0] w;
      bit g;
      w = {wr, 3'(cnt), 2'b11, 10'(addr)};
      for (int i = 0; i < 16; i++) begin
         sbit(lsb ? w[i] : w[15 - i], g);
      end
   endtask

   function automatic int next_addr(input int a);
      return lsb ? ((a + 1) & 1023) : ((a + 1023) & 1023);
   endfunction

   task automatic wr_burst(input int cnt, input int addr);
      int a;
      bit g;
      send_cmd(1'b1, cnt, addr);
      a = addr;
      for (int k = 0; k <= cnt; k++) begin
         if (a < NREG) begin
            exp_a.push_back(a);
            exp_d.push_back(int'(wbuf[k]));
         end
         for (int i = 0; i < 8; i++) begin
            sbit(lsb ? wbuf[k][i] : wbuf[k][7 - i], g);
         end
         a = next_addr(a);
      end
   endtask

   task automatic rd_burst(input int cnt, input int addr, input string req);
      int a;
      bit g;
      logic [7:0] got;
      logic [7:0] exp;
      send_cmd(1'b0, cnt, addr);
      a = addr;
      for (int k = 0; k <= cnt; k++) begin
         exp = (a < NREG) ? regs[a] : 8'h00;
         for (int i = 0; i < 8; i++) begin
            sbit(1'b0, g);
            if (lsb) got[i] = g;
            else got[7 - i] = g;
         end
         check(got == exp, req, $sformatf("read byte %0d at addr 0x%0h", k, a),
               int'(got), int'(exp));
         a = next_addr(a);
      end
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) regs[i] = 8'((i * 37 + 11) ^ (i >> 3));
      tick(5);
      rst_n = 1'b1;
      tick(3);
      // R11: reset state
      check(reg_we == 1'b0, "R11", "reg_we after reset", int'(reg_we), 0);
      check(sdo == 1'b0, "R11", "sdo after reset", int'(sdo), 0);

      // R1 R2 R3 R7: single byte, most significant bit first
      lsb = 1'b0;
      wbuf[0] = 8'h55;
      sel(); wr_burst(0, 'h15A); desel();
      sel(); rd_burst(0, 'h15A, "R8"); desel();

      // R3: four-byte write with falling addresses, read back both ways
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
      sel(); wr_burst(3, 'h02A); desel();
      sel(); rd_burst(3, 'h02A, "R3"); desel();
      sel(); rd_burst(0, 'h028, "R3"); desel();

      // R4: whole word reversed, rising addresses
      lsb = 1'b1;
      wbuf[0] = 8'h1E; wbuf[1] = 8'h2D; wbuf[2] = 8'h3C; wbuf[3] = 8'h4B;
      sel(); wr_burst(3, 'h02A); desel();
      sel(); rd_burst(3, 'h02A, "R4"); desel();
      lsb = 1'b0;
      sel(); rd_burst(0, 'h02D, "R4"); desel();

      // R5 R6: downward wrap into undefined space
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
      sel(); wr_burst(3, 'h001); desel();
      sel(); rd_burst(3, 'h001, "R5"); desel();
      sel(); rd_burst(0, 'h3FF, "R6"); desel();

      // R5 R6: upward wrap out of undefined space
      lsb = 1'b1;
      wbuf[0] = 8'h66; wbuf[1] = 8'h77; wbuf[2] = 8'h88; wbuf[3] = 8'h99;
      sel(); wr_burst(3, 'h3FE); desel();
      sel(); rd_burst(3, 'h3FE, "R5"); desel();
      sel(); rd_burst(1, 'h27F, "R6"); desel();

      // R2: maximum count of eight bytes
      lsb = 1'b0;
      for (int k = 0; k < 8; k++) wbuf[k] = 8'(8'hF0 + k);
      sel(); wr_burst(7, 'h107); desel();
      sel(); rd_burst(7, 'h107, "R2"); desel();
      sel(); rd_burst(0, 'h0FF, "R2"); desel();

      // R9: chained commands under one selection
      wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
      sel();
      wr_burst(1, 'h200);
      rd_burst(1, 'h200, "R9");
      wr_burst(0, 'h210);
      rd_burst(0, 'h210, "R9");
      desel();

      // R10: abort in the middle of a data byte, then a clean restart
      begin
         bit g;
         logic [7:0] keep;
         keep = regs['h010];
         sel();
         send_cmd(1'b1, 0, 'h010);
         for (int i = 0; i < 4; i++) sbit(1'b1, g);
         desel();
         sel(); rd_burst(0, 'h010, "R10"); desel();
         check(regs['h010] == keep, "R10", "register after abort", int'(regs['h010]), int'(keep));
         // abort inside the command word
         sel();
         for (int i = 0; i < 7; i++) sbit(1'b1, g);
         desel();
         wbuf[0] = 8'h3C;
         sel(); wr_burst(0, 'h011); desel();
         sel(); rd_burst(0, 'h011, "R10"); desel();
      end

      tick(20);
      // R7: every expected write strobe arrived
      check(exp_a.size() == 0, "R7", "pending writes", exp_a.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired before the run completed");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule